// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This controller sits between a clocked host and an external asynchronous static RAM of 262,144 sixteen-bit words. The host presents one request at a time through a valid/ready handshake. Each request carries an 18-bit word address, a write flag, two byte-enable bits and 16 bits of write data. When the transfer is over the controller returns a one-cycle done pulse, and after a read it also returns the data. On the memory side it drives the active-low chip select, output enable, write strobe and the two lane selects. It also drives the address and a split data bus, with a drive-enable for the external tri-state buffer.

Every phase is a whole number of system clocks. Each count is the nanosecond minimum divided by the clock period and rounded up; one parameter set covers one speed grade. A read holds the select and output enable low for the access time and captures the bus on the edge that ends that phase. It then waits out the time the memory may keep driving the bus. A write keeps output enable high throughout and ends on the rising edge of the write strobe. Its length is the longest of three times: the pulse width, the data setup and the select-to-end time.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, all five strobes are high, the drive-enable is low, ready is high and done is low.
- R2: A request is taken only on a clock edge where valid and ready are both high. Ready stays low from acceptance until the controller is idle again. A request offered while ready is low has no effect on memory.
- R3: A read holds chip select and output enable low and the write strobe high for exactly ceil(T_ACCESS_NS/CLK_PERIOD_NS) cycles (3 at defaults), with the drive-enable low.
- R4: Read data is sampled on the edge that releases the read strobes. Done is high for the one cycle after that edge, and the read data is valid in that same cycle.
- R5: Byte-enable bit 0 maps to the lower lane select (data bits 7:0) and bit 1 to the upper lane select (bits 15:8). A lane that is not selected is not strobed, is not written, and returns zero in read data.
- R6: A write holds chip select and the write strobe low, output enable high and the drive-enable high, with the write data on the bus. It lasts exactly the largest of the rounded-up pulse, setup and select-to-end counts (3 at defaults).
- R7: At the end of a write, all strobes and the drive-enable are released on the same edge. Done is high in the following cycle, and ready is already high in that cycle.
- R8: After a read, ready stays low for ceil(T_RELEASE_NS/CLK_PERIOD_NS) cycles (2 at defaults), counted from the done cycle, with all strobes high. The drive-enable is never high while output enable is low.
- R9: A request with both byte enables zero produces done in the next cycle with no strobe activity, and ready stays high.
- R10: The address is registered at acceptance and stays stable while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte enables: bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for the data bus buffer |
| mem_dq_in | input | 16 | Data returned from the memory |

## Verification
The bench's memory model returns garbage until the access time has elapsed. A controller that samples one edge early therefore returns a wrong word, and one that lengthens the access shows it in the strobe count. Single-lane writes followed by full reads expose a lane map that is swapped or ignored, because the untouched byte changes. The model also drives a marker on unselected lanes, so a missing lane mask shows up in read data. Requests offered while busy, and requests with zero byte enables, are followed by read-back, so a controller that accepts too early or strobes anyway corrupts memory. A bus-contention counter, together with the ready-low count after reads, catches a missing or short turnaround.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_ACCESS_NS   = 55,
  parameter int T_WPULSE_NS   = 40,
  parameter int T_SEL_END_NS  = 45,
  parameter int T_DSETUP_NS   = 25,
  parameter int T_RELEASE_NS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int LANE_W  = DATA_W / 2;
  localparam int RD_RAW  = (T_ACCESS_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WP_RAW  = (T_WPULSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int SE_RAW  = (T_SEL_END_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int DS_RAW  = (T_DSETUP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int TA_RAW  = (T_RELEASE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RD_CYC  = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int WR_A    = (WP_RAW > SE_RAW) ? WP_RAW : SE_RAW;
  localparam int WR_B    = (WR_A > DS_RAW) ? WR_A : DS_RAW;
  localparam int WR_CYC  = (WR_B < 1) ? 1 : WR_B;
  localparam int TA_CYC  = (TA_RAW < 1) ? 1 : TA_RAW;
  localparam int MAX_AB  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAX_CYC = (MAX_AB > TA_CYC) ? MAX_AB : TA_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_TURN} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         lane_n;
  logic [DATA_W-1:0]  lane_mask;
  logic               phase_end;

  assign req_ready = (state == S_IDLE);
  assign mem_lb_n  = lane_n[0];
  assign mem_ub_n  = lane_n[1];
  assign phase_end = (cnt == CNT_W'(1));

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{~lane_n[g]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      lane_n     <= 2'b11;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (req_be == 2'b00) begin
              rsp_done <= 1'b1;
            end else begin
              mem_addr <= req_addr;
              lane_n   <= ~req_be;
              mem_ce_n <= 1'b0;
              if (req_write) begin
                mem_we_n   <= 1'b0;
                mem_dq_oe  <= 1'b1;
                mem_dq_out <= req_wdata;
                cnt        <= CNT_W'(WR_CYC);
                state      <= S_WRITE;
              end else begin
                mem_oe_n <= 1'b0;
                cnt      <= CNT_W'(RD_CYC);
                state    <= S_READ;
              end
            end
          end
        end
        S_READ: begin
          if (phase_end) begin
            rsp_rdata <= mem_dq_in & lane_mask;
            rsp_done  <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            lane_n    <= 2'b11;
            cnt       <= CNT_W'(TA_CYC);
            state     <= S_TURN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WRITE: begin
          if (phase_end) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            lane_n    <= 2'b11;
            rsp_done  <= 1'b1;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (phase_end) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  logic [CNT_W:0] rd_run, wr_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= mem_oe_n ? '0 : rd_run + 1'b1;
      wr_run <= mem_we_n ? '0 : wr_run + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_read_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (rd_run == (CNT_W+1)'(RD_CYC)));

  p_write_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wr_run == (CNT_W+1)'(WR_CYC)));

  p_write_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!req_ready && rsp_done));

  p_zero_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_be == 2'b00) |=> (rsp_done && mem_ce_n && req_ready));

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  localparam int RD_EXP = 3;
  localparam int WR_EXP = 3;
  localparam int TA_EXP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [17:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;

  int checks = 0;
  int fails = 0;
  int contention = 0;

  always #10 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  logic [15:0] sram [0:255];
  logic        rd_act;
  int          rd_age = 0;

  initial for (int i = 0; i < 256; i++) sram[i] = '0;

  assign rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;

  always @(posedge clk) begin
    rd_age <= rd_act ? rd_age + 1 : 0;
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) sram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) sram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  always_comb begin
    if (!rd_act) mem_dq_in = 16'hA5A5;
    else if (rd_age < RD_EXP - 1) mem_dq_in = 16'h5A5A;
    else mem_dq_in = {mem_ub_n ? 8'hEE : sram[mem_addr[7:0]][15:8],
                      mem_lb_n ? 8'hEE : sram[mem_addr[7:0]][7:0]};
  end

  always @(negedge clk) if (mem_dq_oe && rd_act) contention++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic run_req(input bit wr, input logic [17:0] a, input logic [1:0] be,
                         input logic [15:0] wd, input bit intrude,
                         output logic [15:0] rd, output int lat, output int act,
                         output int bad, output int turn);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    lat = 0; act = 0; bad = 0;
    do begin
      @(negedge clk);
      lat++;
      if (intrude && lat < 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 18'h1;
        req_be = 2'b11; req_wdata = 16'hBAD0;
      end else req_valid = 1'b0;
      if (!mem_ce_n) begin
        act++;
        if (mem_addr != a) bad++;
        if ({mem_ub_n, mem_lb_n} != ~be) bad++;
        if (wr) begin
          if (mem_we_n || !mem_oe_n || !mem_dq_oe || mem_dq_out != wd) bad++;
        end else begin
          if (!mem_we_n || mem_oe_n || mem_dq_oe) bad++;
        end
      end else if (!mem_we_n || !mem_oe_n || !mem_lb_n || !mem_ub_n || mem_dq_oe) bad++;
    end while (!rsp_done && lat < 20);
    req_valid = 1'b0;
    rd = rsp_rdata;
    turn = 0;
    while (!req_ready && turn < 10) begin
      turn++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [17:0] a, input logic [1:0] be, input logic [15:0] wd, input string tag);
    logic [15:0] rd; int lat, act, bad, turn;
    run_req(1'b1, a, be, wd, 1'b0, rd, lat, act, bad, turn);
    chk(act == WR_EXP, {tag, " R6 write strobe cycles"}, act, WR_EXP);
    chk(bad == 0, {tag, " R6 write strobe values"}, bad, 0);
    chk(lat == WR_EXP + 1 && turn == 0, {tag, " R7 write done timing"}, lat * 16 + turn, (WR_EXP + 1) * 16);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be, input logic [15:0] exp, input string tag);
    logic [15:0] rd; int lat, act, bad, turn;
    run_req(1'b0, a, be, 16'h0, 1'b0, rd, lat, act, bad, turn);
    chk(act == RD_EXP, {tag, " R3 read strobe cycles"}, act, RD_EXP);
    chk(bad == 0, {tag, " R3 read strobe values"}, bad, 0);
    chk(lat == RD_EXP + 1, {tag, " R4 done latency"}, lat, RD_EXP + 1);
    chk(rd == exp, {tag, " R4 R5 read data"}, rd, exp);
    chk(turn == TA_EXP, {tag, " R8 turnaround"}, turn, TA_EXP);
  endtask

  task automatic t_reset();
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n, "R1 strobes idle",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1f);
    chk(!mem_dq_oe && req_ready && !rsp_done, "R1 handshake idle",
        {mem_dq_oe, req_ready, rsp_done}, 3'b010);
  endtask

  task automatic t_full_word();
    do_write(18'h00010, 2'b11, 16'h1234, "full");
    do_read(18'h00010, 2'b11, 16'h1234, "full");
  endtask

  task automatic t_lanes();
    do_write(18'h00010, 2'b01, 16'hAB77, "R5 lower");
    do_read(18'h00010, 2'b11, 16'h1277, "R5 lower");
    do_write(18'h00010, 2'b10, 16'hCD99, "R5 upper");
    do_read(18'h00010, 2'b11, 16'hCD77, "R5 upper");
    do_read(18'h00010, 2'b01, 16'h0077, "R5 lower read");
    do_read(18'h00010, 2'b10, 16'hCD00, "R5 upper read");
  endtask

  task automatic t_zero_be();
    logic [15:0] rd; int lat, act, bad, turn;
    run_req(1'b1, 18'h00010, 2'b00, 16'hFFFF, 1'b0, rd, lat, act, bad, turn);
    chk(lat == 1 && act == 0 && bad == 0 && turn == 0, "R9 zero enables",
        {lat[7:0], act[7:0], bad[7:0], turn[7:0]}, 32'h01000000);
    do_read(18'h00010, 2'b11, 16'hCD77, "R9 unchanged");
  endtask

  task automatic t_edges();
    do_write(18'h00000, 2'b11, 16'h0F0F, "R10 low");
    do_write(18'h3FFFF, 2'b11, 16'hF0F0, "R10 high");
    do_read(18'h00000, 2'b11, 16'h0F0F, "R10 low");
    do_read(18'h3FFFF, 2'b11, 16'hF0F0, "R10 high");
  endtask

  task automatic t_busy();
    logic [15:0] rd; int lat, act, bad, turn;
    do_write(18'h00021, 2'b11, 16'h4321, "R2 setup");
    run_req(1'b0, 18'h00020, 2'b11, 16'h0, 1'b1, rd, lat, act, bad, turn);
    chk(act == RD_EXP && bad == 0, "R2 busy read intact", act, RD_EXP);
    do_read(18'h00021, 2'b11, 16'h4321, "R2 offer ignored");
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog R2 actual=hang expected=finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_word();
    t_lanes();
    t_zero_be();
    t_edges();
    t_busy();
    chk(contention == 0, "R8 bus contention", contention, 0);
    report();
  end

endmodule